// File: doc/BRIEF.md
# Snooped Shared-Line Access Controller

This block watches processor bus operations aimed at a window of local physical memory that holds globally shared pages. Pages are placed in that window whole, but permission is kept for each cache line as a 2-bit state. For every snooped operation, the block looks up the line's state. It then reads a small programmable table, indexed by state and operation type, to pick one of three responses:

- let the access finish against local memory;
- let it finish and also post a notice to the service processor;
- make the processor retry the operation and post a request to the service processor.

The block never changes a line state by itself. Only the service processor writes line states and table entries. Notices and requests wait in a small forward queue that the service processor drains. An operation that is refused keeps being retried until software has made its line legal. Operations outside the window always proceed.

Top module: `snoop_access_ctrl`

## Requirements
- R1: An operation whose address falls outside the snooped window (window base `WIN_BASE`, length `WIN_LINES` lines of `2**LINE_SHIFT` bytes) gets action 0 (proceed) and queues nothing, whatever the table holds.
- R2: For each cycle with `bus_valid` high, `resp_valid` is high for exactly one cycle, two cycles later, carrying that operation's action.
- R3: Inside the window, the action is table entry `state*4 + op`. Line states are 0 invalid, 1 read-only, 2 read-write, 3 busy. Operations are 0 read, 1 read-with-intent-to-modify, 2 write, 3 invalidate. Actions are 0 proceed, 1 proceed and notify, 2 retry and request. A stored value of 3 is presented as 2, so `resp_action` never shows 3.
- R4: After reset, every line is invalid. The table then gives:
  - invalid: action 2 for every operation;
  - read-only: action 0 for read, action 2 for the other operations;
  - read-write: action 0 for every operation;
  - busy: action 2 for every operation.
- R5: An action of 1 or 2 inside the window pushes the operation's address and type into the forward queue. Action 0 pushes nothing.
- R6: When the 8-entry forward queue is full, an operation that would have been forwarded gets action 2 and is not queued. The queued entries stay unchanged.
- R7: Bus operations never change a line state. A refused operation repeated on the same line gets the same action until the service processor writes the line state.
- R8: A service-processor write to a line state or a table entry applies to every operation snooped after the write's clock edge.
- R9: The forward queue delivers entries in arrival order. `fwd_valid` is low when the queue is empty. `fwd_pop` with `fwd_valid` high removes the head.
- R10: The line index is (address - `WIN_BASE`) >> `LINE_SHIFT`. All addresses in one line share a state, and the last line of the window is inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Address phase of a snooped operation |
| bus_addr | input | ADDR_W | Operation address |
| bus_op | input | 2 | Operation type |
| resp_valid | output | 1 | Response window strobe |
| resp_action | output | 2 | Chosen action |
| sp_line_we | input | 1 | Service processor line state write |
| sp_line_idx | input | IDX_W | Line to write |
| sp_line_state | input | 2 | New line state |
| sp_tbl_we | input | 1 | Service processor table write |
| sp_tbl_idx | input | 4 | Table entry (state*4+op) |
| sp_tbl_action | input | 2 | New action for the entry |
| fwd_valid | output | 1 | Forward queue head is valid |
| fwd_addr | output | ADDR_W | Head address |
| fwd_op | output | 2 | Head operation type |
| fwd_pop | input | 1 | Remove head entry |

## Verification
On every cycle, the assertions check several properties:

- the fixed two-cycle response spacing;
- that out-of-window operations proceed;
- that the reserved action code never reaches the bus;
- that a push never happens into a full queue;
- that the queue occupancy follows forwarded responses and pops.

Only the bench scenarios can show the actual lookup results. These include the reset table contents and the line-index mapping at window edges. They also include persistence of a retry until software writes the line, the effect of reprogrammed table entries, and the order and contents of queued notices after the queue has filled and drained.

// File: rtl/snp_pkg.sv
`timescale 1ns/1ps
package snp_pkg;

    typedef enum logic [1:0] {LS_INV = 2'd0, LS_RO = 2'd1, LS_RW = 2'd2, LS_BUSY = 2'd3} line_st_e;
    typedef enum logic [1:0] {OP_RD = 2'd0, OP_RWITM = 2'd1, OP_WR = 2'd2, OP_INVAL = 2'd3} bus_op_e;
    typedef enum logic [1:0] {ACT_GO = 2'd0, ACT_GO_NOTE = 2'd1, ACT_RETRY = 2'd2, ACT_RSVD = 2'd3} act_e;

    // Table contents loaded at reset
    function automatic act_e reset_action(input logic [3:0] idx);
        line_st_e st;
        bus_op_e  op;
        st = line_st_e'(idx[3:2]);
        op = bus_op_e'(idx[1:0]);
        case (st)
            LS_RW:   reset_action = ACT_GO;
            LS_RO:   reset_action = (op == OP_RD) ? ACT_GO : ACT_RETRY;
            default: reset_action = ACT_RETRY;
        endcase
    endfunction

endpackage

// File: rtl/snp_line_state.sv
`timescale 1ns/1ps
module snp_line_state
    import snp_pkg::*;
#(
    parameter int LINES = 64,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_st_e         wr_state,
    input  logic [IDX_W-1:0] rd_idx,
    output line_st_e         rd_state
);

    line_st_e st_d [LINES];
    line_st_e st_q [LINES];

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            st_d[i] = st_q[i];
        end
        if (wr_en) begin
            st_d[wr_idx] = wr_state;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) st_q[i] <= LS_INV;
            else        st_q[i] <= st_d[i];
        end
    end

    assign rd_state = st_q[rd_idx];

endmodule

// File: rtl/snp_action_table.sv
`timescale 1ns/1ps
module snp_action_table
    import snp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_idx,
    input  act_e       wr_act,
    input  line_st_e   st,
    input  bus_op_e    op,
    output act_e       act
);

    localparam int ENTRIES = 16;

    act_e tbl_d [ENTRIES];
    act_e tbl_q [ENTRIES];
    act_e raw;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            tbl_d[i] = tbl_q[i];
        end
        if (wr_en) begin
            tbl_d[wr_idx] = wr_act;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) tbl_q[i] <= reset_action(4'(i));
            else        tbl_q[i] <= tbl_d[i];
        end
    end

    assign raw = tbl_q[{st, op}];
    assign act = (raw == ACT_RSVD) ? ACT_RETRY : raw;

endmodule

// File: rtl/snp_fwd_fifo.sv
`timescale 1ns/1ps
module snp_fwd_fifo
    import snp_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  bus_op_e           push_op,
    input  logic              pop,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output bus_op_e           out_op,
    output logic              full,
    output logic [CNT_W-1:0]  count
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        bus_op_e           op;
    } fwd_ent_t;

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t     ctl_d, ctl_q;
    fwd_ent_t mem_d [DEPTH];
    fwd_ent_t mem_q [DEPTH];
    logic     do_push, do_pop;

    assign full      = (ctl_q.cnt == CNT_W'(DEPTH));
    assign out_valid = (ctl_q.cnt != '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && out_valid;

    always_comb begin
        ctl_d = ctl_q;
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (do_push) begin
            mem_d[ctl_q.wr] = '{addr: push_addr, op: push_op};
            ctl_d.wr = (ctl_q.wr == PTR_W'(DEPTH - 1)) ? '0 : ctl_q.wr + 1'b1;
        end
        if (do_pop) begin
            ctl_d.rd = (ctl_q.rd == PTR_W'(DEPTH - 1)) ? '0 : ctl_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   ctl_d.cnt = ctl_q.cnt + 1'b1;
            2'b01:   ctl_d.cnt = ctl_q.cnt - 1'b1;
            default: ctl_d.cnt = ctl_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= mem_d[i];
        end
    end

    assign out_addr = mem_q[ctl_q.rd].addr;
    assign out_op   = mem_q[ctl_q.rd].op;
    assign count    = ctl_q.cnt;

endmodule

// File: rtl/snoop_access_ctrl.sv
`timescale 1ns/1ps
module snoop_access_ctrl
    import snp_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              LINE_SHIFT = 6,
    parameter int              WIN_LINES  = 64,
    parameter logic [31:0]     WIN_BASE   = 32'h0001_0000,
    parameter int              FQ_DEPTH   = 8,
    localparam int             IDX_W      = $clog2(WIN_LINES),
    localparam int             CNT_W      = $clog2(FQ_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_op,
    output logic              resp_valid,
    output logic [1:0]        resp_action,
    input  logic              sp_line_we,
    input  logic [IDX_W-1:0]  sp_line_idx,
    input  logic [1:0]        sp_line_state,
    input  logic              sp_tbl_we,
    input  logic [3:0]        sp_tbl_idx,
    input  logic [1:0]        sp_tbl_action,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [1:0]        fwd_op,
    input  logic              fwd_pop
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(WIN_LINES) << LINE_SHIFT;

    typedef struct packed {
        logic              vld;
        logic              inwin;
        logic [ADDR_W-1:0] addr;
        bus_op_e           op;
        logic [IDX_W-1:0]  idx;
    } snoop_t;

    typedef struct packed {
        logic vld;
        logic inwin;
        act_e act;
    } resp_t;

    snoop_t            s1_d, s1_q;
    resp_t             rsp_d, rsp_q;
    logic [ADDR_W-1:0] offset;
    line_st_e          cur_state;
    act_e              tbl_act;
    logic              fq_full, fq_push;
    logic [CNT_W-1:0]  fq_count;
    bus_op_e           head_op;

    snp_line_state #(.LINES(WIN_LINES)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sp_line_we),
        .wr_idx   (sp_line_idx),
        .wr_state (line_st_e'(sp_line_state)),
        .rd_idx   (s1_q.idx),
        .rd_state (cur_state)
    );

    snp_action_table u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (sp_tbl_we),
        .wr_idx (sp_tbl_idx),
        .wr_act (act_e'(sp_tbl_action)),
        .st     (cur_state),
        .op     (s1_q.op),
        .act    (tbl_act)
    );

    snp_fwd_fifo #(.DEPTH(FQ_DEPTH), .ADDR_W(ADDR_W)) u_fwdq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fq_push),
        .push_addr (s1_q.addr),
        .push_op   (s1_q.op),
        .pop       (fwd_pop),
        .out_valid (fwd_valid),
        .out_addr  (fwd_addr),
        .out_op    (head_op),
        .full      (fq_full),
        .count     (fq_count)
    );

    assign offset = bus_addr - BASE;

    always_comb begin
        logic wants_fwd;
        // address phase capture
        s1_d.vld   = bus_valid;
        s1_d.inwin = (bus_addr >= BASE) && (offset < SPAN);
        s1_d.addr  = bus_addr;
        s1_d.op    = bus_op_e'(bus_op);
        s1_d.idx   = offset[LINE_SHIFT +: IDX_W];

        // lookup and decision
        wants_fwd  = s1_q.inwin && (tbl_act != ACT_GO);
        fq_push    = s1_q.vld && wants_fwd && !fq_full;
        rsp_d.vld   = s1_q.vld;
        rsp_d.inwin = s1_q.inwin;
        if (!s1_q.inwin)               rsp_d.act = ACT_GO;
        else if (wants_fwd && fq_full) rsp_d.act = ACT_RETRY;
        else                           rsp_d.act = tbl_act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q  <= '0;
            rsp_q <= '0;
        end else begin
            s1_q  <= s1_d;
            rsp_q <= rsp_d;
        end
    end

    assign resp_valid  = rsp_q.vld;
    assign resp_action = rsp_q.act;
    assign fwd_op      = head_op;

endmodule

// File: rtl/snoop_access_chk.sv
`timescale 1ns/1ps
module snoop_access_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             resp_valid,
    input logic [1:0]       resp_action,
    input logic             resp_inwin,
    input logic             fq_push,
    input logic             fq_full,
    input logic [CNT_W-1:0] fq_count,
    input logic             fwd_valid,
    input logic             fwd_pop
);

    logic [1:0] age_q;
    logic       warm;
    logic       pop_fire;

    always_ff @(posedge clk) begin
        if (!rst_n)            age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    assign warm     = (age_q == 2'd2);
    assign pop_fire = fwd_pop && fwd_valid;

    // R2
    resp_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (resp_valid == $past(bus_valid, 2)));

    // R1
    outside_proceed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_inwin) |-> (resp_action == 2'd0));

    // R3
    no_rsvd_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_action != 2'd3));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fq_full |-> !fq_push);

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fq_count) <= DEPTH);

    // R5
    notice_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && resp_valid && resp_action == 2'd1) |->
            (int'(fq_count) == int'($past(fq_count)) + 1 - int'($past(pop_fire))));

endmodule

bind snoop_access_ctrl snoop_access_chk #(.DEPTH(FQ_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .resp_valid  (resp_valid),
    .resp_action (resp_action),
    .resp_inwin  (rsp_q.inwin),
    .fq_push     (fq_push),
    .fq_full     (fq_full),
    .fq_count    (fq_count),
    .fwd_valid   (fwd_valid),
    .fwd_pop     (fwd_pop)
);

// File: tb/snoop_access_ctrl_tb_top.sv
`timescale 1ns/1ps
module snoop_access_ctrl_tb_top;

    localparam int          ADDR_W = 32;
    localparam int          IDX_W  = 6;
    localparam logic [31:0] BASE   = 32'h0001_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [1:0]        bus_op = '0;
    logic              resp_valid;
    logic [1:0]        resp_action;
    logic              sp_line_we = 1'b0;
    logic [IDX_W-1:0]  sp_line_idx = '0;
    logic [1:0]        sp_line_state = '0;
    logic              sp_tbl_we = 1'b0;
    logic [3:0]        sp_tbl_idx = '0;
    logic [1:0]        sp_tbl_action = '0;
    logic              fwd_valid;
    logic [ADDR_W-1:0] fwd_addr;
    logic [1:0]        fwd_op;
    logic              fwd_pop = 1'b0;

    int checks = 0;
    int failures = 0;
    logic [33:0] model_q [$];

    always #2.5 clk = ~clk;

    snoop_access_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_op(bus_op),
        .resp_valid(resp_valid), .resp_action(resp_action),
        .sp_line_we(sp_line_we), .sp_line_idx(sp_line_idx), .sp_line_state(sp_line_state),
        .sp_tbl_we(sp_tbl_we), .sp_tbl_idx(sp_tbl_idx), .sp_tbl_action(sp_tbl_action),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_op(fwd_op), .fwd_pop(fwd_pop)
    );

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] line_addr(input int n);
        return BASE + 32'(n) * 32'd64;
    endfunction

    // Issue one operation and check its response; model forwards
    task automatic issue(input logic [31:0] a, input logic [1:0] op,
                         input logic [1:0] exp, input string req);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_op = op;
        @(negedge clk);
        bus_valid = 1'b0;
        check(resp_valid == 1'b0, "R2 early", longint'(resp_valid), 0);
        @(negedge clk);
        check(resp_valid == 1'b1, "R2 strobe", longint'(resp_valid), 1);
        check(resp_action == exp, req, longint'(resp_action), longint'(exp));
        if (exp != 2'd0 && model_q.size() < 8) model_q.push_back({a, op});
        @(negedge clk);
        check(resp_valid == 1'b0, "R2 single", longint'(resp_valid), 0);
    endtask

    task automatic set_line(input int idx, input logic [1:0] st);
        @(negedge clk);
        sp_line_we = 1'b1; sp_line_idx = IDX_W'(idx); sp_line_state = st;
        @(negedge clk);
        sp_line_we = 1'b0;
    endtask

    task automatic set_tbl(input int idx, input logic [1:0] a);
        @(negedge clk);
        sp_tbl_we = 1'b1; sp_tbl_idx = 4'(idx); sp_tbl_action = a;
        @(negedge clk);
        sp_tbl_we = 1'b0;
    endtask

    // Pop everything, comparing against the model (R9)
    task automatic drain(input string req);
        while (fwd_valid) begin
            logic [33:0] e;
            if (model_q.size() == 0) begin
                check(1'b0, req, longint'({fwd_addr, fwd_op}), 0);
                e = '0;
            end else begin
                e = model_q.pop_front();
                check({fwd_addr, fwd_op} == e, req, longint'({fwd_addr, fwd_op}), longint'(e));
            end
            fwd_pop = 1'b1;
            @(negedge clk);
            fwd_pop = 1'b0;
        end
        check(model_q.size() == 0, req, longint'(model_q.size()), 0);
        check(fwd_valid == 1'b0, "R9 empty", longint'(fwd_valid), 0);
        model_q.delete();
    endtask

    task automatic t_reset;
        check(resp_valid == 1'b0, "R4 resp idle", longint'(resp_valid), 0);
        check(fwd_valid == 1'b0, "R9 queue empty", longint'(fwd_valid), 0);
        issue(line_addr(3), 2'd0, 2'd2, "R4 invalid read");
        issue(line_addr(3), 2'd3, 2'd2, "R4 invalid inval");
        drain("R5 reset notices");
    endtask

    task automatic t_default_table;
        set_line(1, 2'd1);
        set_line(2, 2'd2);
        set_line(4, 2'd3);
        issue(line_addr(1), 2'd0, 2'd0, "R4 ro read");
        issue(line_addr(1), 2'd2, 2'd2, "R4 ro write");
        issue(line_addr(1), 2'd1, 2'd2, "R4 ro rwitm");
        issue(line_addr(1), 2'd0, 2'd0, "R7 ro kept");
        issue(line_addr(2), 2'd2, 2'd0, "R4 rw write");
        issue(line_addr(2), 2'd3, 2'd0, "R4 rw inval");
        issue(line_addr(4), 2'd0, 2'd2, "R4 busy read");
        drain("R5 default notices");
    endtask

    task automatic t_window;
        issue(32'h0000_0040, 2'd2, 2'd0, "R1 below window");
        issue(BASE + 32'h1000, 2'd0, 2'd0, "R1 past window");
        issue(BASE - 32'd1, 2'd1, 2'd0, "R1 just below");
        check(fwd_valid == 1'b0, "R1 no notice", longint'(fwd_valid), 0);
        issue(line_addr(63), 2'd0, 2'd2, "R10 last line");
        set_line(7, 2'd2);
        issue(line_addr(7), 2'd2, 2'd0, "R10 line start");
        issue(line_addr(7) + 32'd60, 2'd2, 2'd0, "R10 line end");
        issue(line_addr(8), 2'd2, 2'd2, "R10 next line");
        drain("R10 notices");
    endtask

    task automatic t_retry_persist;
        issue(line_addr(9), 2'd2, 2'd2, "R7 first retry");
        issue(line_addr(9), 2'd2, 2'd2, "R7 retry again");
        set_line(9, 2'd2);
        issue(line_addr(9), 2'd2, 2'd0, "R7 after sp fix");
        drain("R5 retry requests");
    endtask

    task automatic t_program;
        set_tbl(0, 2'd1);
        issue(line_addr(11), 2'd0, 2'd1, "R8 notify entry");
        check(fwd_valid == 1'b1, "R5 notice queued", longint'(fwd_valid), 1);
        set_tbl(10, 2'd3);
        issue(line_addr(2), 2'd2, 2'd2, "R3 reserved code");
        set_tbl(0, 2'd0);
        issue(line_addr(11), 2'd0, 2'd0, "R8 proceed entry");
        drain("R9 order programmed");
        set_tbl(0, 2'd2);
        set_tbl(10, 2'd0);
    endtask

    task automatic t_full;
        for (int i = 0; i < 8; i++) begin
            issue(line_addr(20 + i), 2'(i), 2'd2, "R5 fill");
        end
        issue(line_addr(30), 2'd0, 2'd2, "R6 full retry");
        set_tbl(0, 2'd1);
        issue(line_addr(31), 2'd0, 2'd2, "R6 notify becomes retry");
        drain("R6 contents kept");
        issue(line_addr(31), 2'd0, 2'd1, "R6 space again");
        drain("R9 after full");
        set_tbl(0, 2'd2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_table();
        t_window();
        t_retry_persist();
        t_program();
        t_full();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule